// File: doc/BRIEF.md
# Frame-Retrace Calibration Line Sequencer

This block turns the digitised levels of a three-level sandcastle into the timing that a display
calibration loop needs. It takes three synchronous flags: composite blanking, burst gate and line
retrace. From the retrace and burst flags it produces a horizontal pulse and a clamp pulse, each one
clock later.

It counts lines on rising edges of the retrace flag. It detects the start of vertical blanking as
blanking that stays high for a whole line period. From that point it stretches the composite blanking
it sends out to a fixed length of 23 counted lines, whatever the length of the incoming vertical part.

Inside that stretched window, lines 17 to 23 carry a test sequence for automatic drive and cut-off
control:
- a drive strobe for the green, red and blue guns in turn;
- one leakage-sample line with all guns blanked;
- a quasi-cut-off strobe for the green, red and blue guns in turn.

A switch output grounds the measurement resistor during the three drive lines. If the incoming vertical
blanking ends too early, the block raises an error flag and withholds the calibration strobes for that
field.

Top module: `vbs_cal_seq`

## Requirements
- R1: `hpulse` equals `sc_retrace` delayed by one clock, and `clamp` equals `sc_burst` delayed by one clock.
- R2: A line boundary is a rising edge of `sc_retrace`. Call a line *full-blank* when `sc_blank` stays high from one line boundary to the next. The boundary that ends the first full-blank line of a field starts counted line 1. Each later boundary advances the count by one.
- R3: `blank_out` is high through counted lines 1 to 23, whatever `sc_blank` does during them. It is low in the active part of the line that follows line 23 when `sc_blank` is low. Outside the counted window, `blank_out` is `sc_blank` delayed by one clock.
- R4: `cal_strobe` bits 0, 1 and 2 (green, red and blue drive) are high in the active part of lines 17, 18 and 19 respectively.
- R5: `cal_strobe` bit 3 (leakage sample) is high in the active part of line 20.
- R6: `cal_strobe` bits 4, 5 and 6 (green, red and blue quasi-cut-off) are high in the active part of lines 21, 22 and 23 respectively.
- R7: `cal_strobe` has at most one bit set. It is all zero in the clock after any clock in which `sc_retrace` is high.
- R8: `rsw_gnd` is high for the whole of lines 17, 18 and 19, and low on every other line.
- R9: If `sc_blank` goes low during counted lines 1 to 11, `short_err` rises. For the rest of that field, `cal_strobe` and `rsw_gnd` stay zero, while `blank_out` still covers all 23 lines.
- R10: `short_err` stays set until counted line 1 of the next field begins, and is then cleared.
- R11: After synchronous reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sc_blank | input | 1 | Composite blanking flag from the sandcastle slicer |
| sc_burst | input | 1 | Burst gate flag from the sandcastle slicer |
| sc_retrace | input | 1 | Line retrace flag from the sandcastle slicer |
| hpulse | output | 1 | Registered horizontal pulse |
| clamp | output | 1 | Registered burst clamp pulse |
| blank_out | output | 1 | Regenerated composite blanking with a 23-line vertical part |
| cal_strobe | output | 7 | One-hot calibration strobes: 0-2 drive G/R/B, 3 leakage, 4-6 cut-off G/R/B |
| rsw_gnd | output | 1 | Measurement resistor grounding switch |
| short_err | output | 1 | Incoming vertical blanking ended before line 12 |

## Verification
The properties rely on a few assumptions about the inputs:
- the three flags are already synchronous to `clk`;
- each retrace pulse lasts several clocks and is followed by an active stretch in every line;
- horizontal blanking stays high past the end of retrace;
- the incoming vertical part is shorter than 24 lines, so a new field never starts inside the stretched window.

The stimulus builds every line from one fixed template of 64 clocks, with retrace, burst and horizontal
blanking in fixed places. It varies only the number of fully blanked lines: 8, 12 and 14. This keeps
every field within those assumptions.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    // Sandcastle flags after level slicing
    typedef struct packed {
        logic blank;
        logic burst;
        logic retr;
    } sc_flags_t;

    // Calibration strobe positions (order is the line order of the test sequence)
    localparam int STB_DRV_G  = 0;
    localparam int STB_DRV_R  = 1;
    localparam int STB_DRV_B  = 2;
    localparam int STB_LEAK   = 3;
    localparam int STB_CUT_G  = 4;
    localparam int STB_CUT_R  = 5;
    localparam int STB_CUT_B  = 6;
    localparam int NUM_STB    = 7;
    localparam int NUM_DRIVE  = 3;

    function automatic int cnt_width(input int max_val);
        return $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/vbs_sc_front.sv
module vbs_sc_front
    import vbs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sc_flags_t sc,
    output logic      line_tick,
    output logic      hpulse_q,
    output logic      clamp_q
);
    logic retr_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            retr_d   <= 1'b0;
            hpulse_q <= 1'b0;
            clamp_q  <= 1'b0;
        end else begin
            retr_d   <= sc.retr;
            hpulse_q <= sc.retr;
            clamp_q  <= sc.burst;
        end
    end

    // Start of a new line: retrace flag rising
    assign line_tick = sc.retr & ~retr_d;

endmodule

// File: rtl/vbs_line_ctr.sv
module vbs_line_ctr #(
    parameter int VERT_LEN  = 23,
    parameter int MIN_LINES = 11,
    parameter int LINE_W    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_tick,
    input  logic              blk,
    output logic [LINE_W-1:0] vcnt,
    output logic              err
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(VERT_LEN);
    localparam logic [LINE_W-1:0] MIN_LINE  = LINE_W'(MIN_LINES);

    // High while blanking has been held since the last line boundary
    logic blk_run;
    logic in_guard;

    assign in_guard = (vcnt != '0) && (vcnt <= MIN_LINE);

    always_ff @(posedge clk) begin
        if (rst) begin
            vcnt    <= '0;
            blk_run <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (line_tick) begin
                blk_run <= blk;
                if (vcnt == '0) begin
                    if (blk_run && blk) begin
                        vcnt <= LINE_W'(1);
                        err  <= 1'b0;
                    end
                end else if (vcnt == LAST_LINE) begin
                    vcnt <= '0;
                end else begin
                    vcnt <= vcnt + LINE_W'(1);
                end
            end else if (!blk) begin
                blk_run <= 1'b0;
            end
            if (!line_tick && !blk && in_guard) begin
                err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/vbs_strobe_dec.sv
module vbs_strobe_dec
    import vbs_pkg::*;
#(
    parameter int CAL_START = 17,
    parameter int LINE_W    = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LINE_W-1:0]  vcnt,
    input  logic               retr,
    input  logic               blk,
    input  logic               err,
    output logic [NUM_STB-1:0] strobe_q,
    output logic               rsw_q,
    output logic               blank_q
);
    localparam logic [LINE_W-1:0] RSW_LO = LINE_W'(CAL_START);
    localparam logic [LINE_W-1:0] RSW_HI = LINE_W'(CAL_START + NUM_DRIVE - 1);

    logic [NUM_STB-1:0] strobe_d;
    logic               rsw_d;

    for (genvar gi = 0; gi < NUM_STB; gi++) begin : g_stb
        localparam logic [LINE_W-1:0] MY_LINE = LINE_W'(CAL_START + gi);
        assign strobe_d[gi] = (vcnt == MY_LINE) & ~retr & ~err;
    end

    assign rsw_d = (vcnt >= RSW_LO) && (vcnt <= RSW_HI) && !err;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= '0;
            rsw_q    <= 1'b0;
            blank_q  <= 1'b0;
        end else begin
            strobe_q <= strobe_d;
            rsw_q    <= rsw_d;
            blank_q  <= blk | (vcnt != '0);
        end
    end

endmodule

// File: rtl/vbs_cal_seq.sv
module vbs_cal_seq
    import vbs_pkg::*;
#(
    parameter int VERT_LEN  = 23,
    parameter int CAL_START = 17,
    parameter int MIN_LINES = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sc_blank,
    input  logic               sc_burst,
    input  logic               sc_retrace,
    output logic               hpulse,
    output logic               clamp,
    output logic               blank_out,
    output logic [NUM_STB-1:0] cal_strobe,
    output logic               rsw_gnd,
    output logic               short_err
);
    localparam int LINE_W = cnt_width(VERT_LEN);

    sc_flags_t         sc;
    logic              line_tick;
    logic [LINE_W-1:0] vcnt;

    assign sc = '{blank: sc_blank, burst: sc_burst, retr: sc_retrace};

    vbs_sc_front u_front (
        .clk       (clk),
        .rst       (rst),
        .sc        (sc),
        .line_tick (line_tick),
        .hpulse_q  (hpulse),
        .clamp_q   (clamp)
    );

    vbs_line_ctr #(
        .VERT_LEN  (VERT_LEN),
        .MIN_LINES (MIN_LINES),
        .LINE_W    (LINE_W)
    ) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .line_tick (line_tick),
        .blk       (sc.blank),
        .vcnt      (vcnt),
        .err       (short_err)
    );

    vbs_strobe_dec #(
        .CAL_START (CAL_START),
        .LINE_W    (LINE_W)
    ) u_dec (
        .clk      (clk),
        .rst      (rst),
        .vcnt     (vcnt),
        .retr     (sc.retr),
        .blk      (sc.blank),
        .err      (short_err),
        .strobe_q (cal_strobe),
        .rsw_q    (rsw_gnd),
        .blank_q  (blank_out)
    );

endmodule

// File: rtl/vbs_cal_seq_chk.sv
module vbs_cal_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       sc_blank,
    input logic       sc_burst,
    input logic       sc_retrace,
    input logic       hpulse,
    input logic       clamp,
    input logic       blank_out,
    input logic [6:0] cal_strobe,
    input logic       rsw_gnd,
    input logic       short_err
);
    // R1
    hpulse_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (hpulse == $past(sc_retrace)));

    // R1
    clamp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (clamp == $past(sc_burst)));

    // R7
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cal_strobe));

    // R7
    strobe_quiet_retr_chk: assert property (@(posedge clk) disable iff (rst)
        sc_retrace |=> (cal_strobe == '0));

    // R3
    strobe_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_strobe != '0) |-> blank_out);

    // R8
    rsw_in_blank_chk: assert property (@(posedge clk) disable iff (rst)
        rsw_gnd |-> blank_out);

    // R4
    drive_with_rsw_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_strobe[2:0] != '0) |-> rsw_gnd);

    // R9
    err_mutes_chk: assert property (@(posedge clk) disable iff (rst)
        (short_err && $past(short_err)) |-> (cal_strobe == '0 && !rsw_gnd));

endmodule

bind vbs_cal_seq vbs_cal_seq_chk u_chk (.*);

// File: tb/tb_vbs_cal_seq.sv
module tb_vbs_cal_seq;

    localparam int LINE_CYC = 64;

    logic       clk = 1'b0;
    logic       rst;
    logic       sc_blank, sc_burst, sc_retrace;
    logic       hpulse, clamp, blank_out, rsw_gnd, short_err;
    logic [6:0] cal_strobe;

    int total = 0;
    int bad   = 0;
    int err_exp = 0;

    always #4 clk = ~clk;

    vbs_cal_seq dut (
        .clk        (clk),
        .rst        (rst),
        .sc_blank   (sc_blank),
        .sc_burst   (sc_burst),
        .sc_retrace (sc_retrace),
        .hpulse     (hpulse),
        .clamp      (clamp),
        .blank_out  (blank_out),
        .cal_strobe (cal_strobe),
        .rsw_gnd    (rsw_gnd),
        .short_err  (short_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one line; j is the line index within the field (negative = before)
    task automatic run_line(input int j, input bit full, input bit chk_all);
        int exp_stb;
        int exp_blank;
        int exp_rsw;
        for (int c = 0; c < LINE_CYC; c++) begin
            @(negedge clk);
            if (c == 3) begin
                check("R1 hpulse in retrace", int'(hpulse), 1);
                if (j >= 17 && j <= 23)
                    check("R7 strobe quiet in retrace", int'(cal_strobe), 0);
            end
            if (c == 11 && chk_all)
                check("R1 clamp in burst", int'(clamp), 1);
            if (c == 40) begin
                exp_stb   = (j >= 17 && j <= 23 && err_exp == 0) ? (1 << (j - 17)) : 0;
                exp_rsw   = (j >= 17 && j <= 19 && err_exp == 0) ? 1 : 0;
                exp_blank = (full || (j >= 1 && j <= 23)) ? 1 : 0;
                if (j >= 17 && j <= 19)      check("R4 drive strobe", int'(cal_strobe), exp_stb);
                else if (j == 20)            check("R5 leakage strobe", int'(cal_strobe), exp_stb);
                else if (j >= 21 && j <= 23) check("R6 cut-off strobe", int'(cal_strobe), exp_stb);
                else if (chk_all)            check("R7 strobe idle", int'(cal_strobe), 0);
                if (chk_all || (j >= 16 && j <= 20))
                    check("R8 rsw_gnd", int'(rsw_gnd), exp_rsw);
                if (chk_all || j == 1 || j >= 23)
                    check("R2 R3 blank_out", int'(blank_out), exp_blank);
                check("R9 R10 short_err", int'(short_err), err_exp);
                if (chk_all) begin
                    check("R1 hpulse idle", int'(hpulse), 0);
                    check("R1 clamp idle", int'(clamp), 0);
                end
            end
            sc_retrace = (c < 8);
            sc_burst   = (c >= 9 && c <= 12);
            sc_blank   = full ? 1'b1 : (c < 12);
        end
    endtask

    // Two normal lines, nfull fully blanked lines, then normal lines to line 25
    task automatic run_field(input int nfull, input bit chk_all);
        run_line(-2, 1'b0, chk_all);
        run_line(-1, 1'b0, chk_all);
        for (int j = 0; j <= 25; j++) begin
            if (j == 1) err_exp = 0;
            if (j == nfull && nfull <= 11) err_exp = 1;
            run_line(j, (j < nfull), chk_all);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1; sc_blank = 1'b0; sc_burst = 1'b0; sc_retrace = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset outputs", int'({hpulse, clamp, blank_out, cal_strobe, rsw_gnd, short_err}), 0);
    endtask

    task automatic test_normal_field();
        run_field(14, 1'b1);
    endtask

    task automatic test_boundary_field();
        run_field(12, 1'b0);
    endtask

    task automatic test_short_field();
        run_field(8, 1'b1);
    endtask

    task automatic test_recovery_field();
        run_field(14, 1'b0);
    endtask

    initial begin
        test_reset();
        test_normal_field();
        test_boundary_field();
        test_short_field();
        test_recovery_field();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule